// File: doc/BRIEF.md
# Diode Emulation Mode Controller

This block chooses, one switching cycle at a time, how the low-side switch of a synchronous buck stage is run. In continuous conduction the low-side switch conducts for the whole off-time as a synchronous rectifier. In emulated-diode operation the block asks for the low-side switch to be turned off once reverse inductor current is seen, so that current cannot flow back into it. Whenever emulated-diode operation is active, the block also tells the modulator to widen its hysteresis window by one third, which lowers the switching frequency.

The inputs are a forced-continuous select level, a strobe that marks the start of every PWM pulse, the low-side gate state, and a phase-node polarity flag (1 = phase above ground while the low-side gate is on, which means reverse inductor current). The block samples the polarity flag once per cycle, a fixed number of clocks after the low-side gate rises. At every PWM strobe it judges the cycle that has just ended. A run of qualifying cycles enters emulated-diode operation. One cycle with forward current returns the block to continuous conduction.

Top module: `dem_ctrl`

## Requirements
- R1: After reset, `dem_o`, `lg_off_req_o` and `win_scale_o` are 0.
- R2: While `force_ccm_i` is 1, `dem_o`, `win_scale_o` and `lg_off_req_o` are 0 in the same cycle, and the qualifying-run count is held at zero. After release, entry needs a fresh run of 8 qualifying cycles.
- R3: The polarity flag is captured once per PWM cycle, at the clock edge that comes SAMPLE_DLY (default 4) edges after the edge at which the low-side gate is first seen high. If the gate falls before that edge, the cycle has no sample and counts as a miss.
- R4: A cycle qualifies when its sample was taken and read 1. At each `pulse_i`, a cycle that does not qualify resets the run count to zero, and the count saturates at ENTRY_RUN.
- R5: `dem_o` rises at the clock edge of the `pulse_i` that closes the 8th (ENTRY_RUN) consecutive qualifying cycle, and not at an earlier one.
- R6: In emulated-diode operation, a cycle whose sample read 0 (forward current) causes `dem_o` to fall at the `pulse_i` edge that closes that cycle.
- R7: In emulated-diode operation, `lg_off_req_o` is 1 from the capture edge of a sample that read 1 until the next `pulse_i` edge. At all other times it is 0.
- R8: `win_scale_o` is 1 (window scaled to 4/3) exactly when `dem_o` is 1.
- R9: In emulated-diode operation, a cycle with no sample does not cause an exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| force_ccm_i | input | 1 | 1 = forced continuous conduction, 0 = emulated diode allowed |
| pulse_i | input | 1 | One-clock strobe at the start of each PWM pulse |
| lg_on_i | input | 1 | Low-side gate state |
| phase_pos_i | input | 1 | Phase-node polarity, 1 = positive (reverse current) |
| dem_o | output | 1 | Emulated-diode operation active |
| lg_off_req_o | output | 1 | Request to turn the low-side switch off |
| win_scale_o | output | 1 | Modulator window select, 1 = 4/3 scale |

## Verification
Runs of qualifying cycles are driven with lengths of seven, eight and more. This separates entry at exactly the eighth strobe from entry one cycle early or late. Runs broken by a negative sample, and runs broken by a low-side pulse too short to be sampled, show that any miss restarts the count, including a missing sample. Inside emulated-diode operation the bench mixes positive, unsampled and negative cycles. This tells apart the turn-off request, holding the mode and exiting on the next strobe. The forced-continuous level is raised both in the middle of a cycle and part-way through a run, to show that the outputs drop at once and that the partial count is discarded.

// File: rtl/dem_pkg.sv
package dem_pkg;
  typedef enum logic {
    MODE_CCM = 1'b0,
    MODE_DEM = 1'b1
  } dem_mode_e;
endpackage

// File: rtl/dem_phase_sampler.sv
module dem_phase_sampler #(
  parameter int SAMPLE_DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic lg_on_i,
  input  logic phase_pos_i,
  output logic smp_vld_o,
  output logic smp_pos_o
);
  localparam int DW = (SAMPLE_DLY > 1) ? $clog2(SAMPLE_DLY) : 1;
  localparam logic [DW-1:0] DLY_LAST = DW'(SAMPLE_DLY - 1);

  logic          lg_q;
  logic          armed_q;
  logic [DW-1:0] dly_q;
  logic          lg_rise;
  logic          capture;

  assign lg_rise = lg_on_i & ~lg_q;
  assign capture = armed_q & lg_on_i & (dly_q == DLY_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lg_q    <= 1'b0;
      armed_q <= 1'b0;
      dly_q   <= '0;
    end else begin
      lg_q <= lg_on_i;
      if (lg_rise) begin
        armed_q <= 1'b1;
        dly_q   <= '0;
      end else if (armed_q) begin
        // gate dropped early or sample taken: disarm
        if (!lg_on_i || capture) armed_q <= 1'b0;
        else                     dly_q   <= dly_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_vld_o <= 1'b0;
      smp_pos_o <= 1'b0;
    end else if (capture) begin
      smp_vld_o <= 1'b1;
      smp_pos_o <= phase_pos_i;
    end else if (pulse_i) begin
      smp_vld_o <= 1'b0;
      smp_pos_o <= 1'b0;
    end
  end

  assert_sample_gate_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smp_vld_o) |-> $past(lg_on_i));
  assert_pos_needs_vld_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_pos_o |-> smp_vld_o);
endmodule

// File: rtl/dem_run_counter.sv
module dem_run_counter #(
  parameter int ENTRY_RUN = 8,
  localparam int CW = $clog2(ENTRY_RUN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          pulse_i,
  input  logic          qual_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(ENTRY_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (clr_i)               cnt_o <= '0;
    else if (pulse_i) begin
      if (!qual_i)                cnt_o <= '0;
      else if (cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
    end
  end

  assert_miss_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !qual_i) |=> (cnt_o == '0));
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_MAX);
  assert_clear_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/dem_mode_fsm.sv
module dem_mode_fsm
  import dem_pkg::*;
#(
  parameter int ENTRY_RUN = 8,
  localparam int CW = $clog2(ENTRY_RUN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          force_ccm_i,
  input  logic          pulse_i,
  input  logic          smp_vld_i,
  input  logic          smp_pos_i,
  input  logic [CW-1:0] cnt_i,
  output dem_mode_e     mode_o
);
  localparam logic [CW-1:0] CNT_ENTRY = CW'(ENTRY_RUN - 1);

  dem_mode_e mode_q, mode_d;
  logic      qual;
  logic      fwd_seen;

  assign qual     = smp_vld_i & smp_pos_i;
  assign fwd_seen = smp_vld_i & ~smp_pos_i;

  always_comb begin
    mode_d = mode_q;
    if (force_ccm_i) begin
      mode_d = MODE_CCM;
    end else if (pulse_i) begin
      unique case (mode_q)
        MODE_CCM: if (qual && cnt_i == CNT_ENTRY) mode_d = MODE_DEM;
        MODE_DEM: if (fwd_seen)                   mode_d = MODE_CCM;
        default:                                  mode_d = MODE_CCM;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_CCM;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  assert_entry_after_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DEM && $past(mode_q) == MODE_CCM) |-> ($past(cnt_i) == CNT_ENTRY));
  assert_exit_on_fwd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DEM && pulse_i && smp_vld_i && !smp_pos_i) |=> (mode_q == MODE_CCM));
  assert_hold_no_sample_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DEM && !force_ccm_i && pulse_i && !smp_vld_i) |=> (mode_q == MODE_DEM));
endmodule

// File: rtl/dem_ctrl.sv
module dem_ctrl
  import dem_pkg::*;
#(
  parameter int ENTRY_RUN  = 8,
  parameter int SAMPLE_DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_ccm_i,
  input  logic pulse_i,
  input  logic lg_on_i,
  input  logic phase_pos_i,
  output logic dem_o,
  output logic lg_off_req_o,
  output logic win_scale_o
);
  localparam int CW = $clog2(ENTRY_RUN + 1);

  logic          smp_vld;
  logic          smp_pos;
  logic [CW-1:0] run_cnt;
  dem_mode_e     mode;

  dem_phase_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) u_sampler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_i     (pulse_i),
    .lg_on_i     (lg_on_i),
    .phase_pos_i (phase_pos_i),
    .smp_vld_o   (smp_vld),
    .smp_pos_o   (smp_pos)
  );

  dem_run_counter #(.ENTRY_RUN(ENTRY_RUN)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (force_ccm_i),
    .pulse_i (pulse_i),
    .qual_i  (smp_vld & smp_pos),
    .cnt_o   (run_cnt)
  );

  dem_mode_fsm #(.ENTRY_RUN(ENTRY_RUN)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .force_ccm_i (force_ccm_i),
    .pulse_i     (pulse_i),
    .smp_vld_i   (smp_vld),
    .smp_pos_i   (smp_pos),
    .cnt_i       (run_cnt),
    .mode_o      (mode)
  );

  // pin level overrides the registered mode without waiting for an edge
  assign dem_o        = (mode == MODE_DEM) & ~force_ccm_i;
  assign win_scale_o  = dem_o;
  assign lg_off_req_o = dem_o & smp_vld & smp_pos;

  assert_force_ccm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ccm_i |-> (!dem_o && !win_scale_o && !lg_off_req_o));
  assert_req_in_dem_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lg_off_req_o |-> dem_o);
  assert_req_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !lg_on_i) |=> !lg_off_req_o);
  assert_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_scale_o == (mode == MODE_DEM && !force_ccm_i));
endmodule

// File: tb/dem_ctrl_tb.sv
`timescale 1ns/1ps
module dem_ctrl_tb;
  localparam int ENTRY_RUN  = 8;
  localparam int SAMPLE_DLY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic force_ccm = 1'b0;
  logic pulse = 1'b0;
  logic lg_on = 1'b0;
  logic phase_pos = 1'b0;
  logic dem, req, win;

  always #2 clk = ~clk;

  dem_ctrl #(.ENTRY_RUN(ENTRY_RUN), .SAMPLE_DLY(SAMPLE_DLY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .force_ccm_i(force_ccm), .pulse_i(pulse),
    .lg_on_i(lg_on), .phase_pos_i(phase_pos),
    .dem_o(dem), .lg_off_req_o(req), .win_scale_o(win)
  );

  typedef struct { logic dem; logic req; string tag; } exp_t;
  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, from the requirements
  bit m_dem = 0, m_vld = 0, m_pos = 0;
  int m_cnt = 0;

  task automatic push(input logic d, input logic r, input string tag);
    exp_t e;
    e.dem = d; e.req = r; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: one expectation per posedge, sampled 1 ns after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (dem !== e.dem || req !== e.req || win !== e.dem) begin
          errors++;
          $display("FAIL %s: dem/req/win=%b%b%b expected %b%b%b", e.tag,
                   dem, req, win, e.dem, e.req, e.dem);
        end
      end
    end
  end

  task automatic pwm_cycle(input bit ph, input int lg_len, input string tag);
    bit qual;
    @(negedge clk);
    pulse = 1'b1;
    qual = m_vld && m_pos;
    if (force_ccm) begin
      m_dem = 0; m_cnt = 0;
    end else begin
      if (!m_dem && qual && m_cnt == ENTRY_RUN - 1) m_dem = 1;
      else if (m_dem && m_vld && !m_pos) m_dem = 0;
      m_cnt = qual ? ((m_cnt < ENTRY_RUN) ? m_cnt + 1 : m_cnt) : 0;
    end
    m_vld = 0; m_pos = 0;
    push(m_dem && !force_ccm, 1'b0, tag);
    @(negedge clk);
    pulse = 1'b0; lg_on = 1'b1; phase_pos = ph;
    repeat (lg_len) @(negedge clk);
    lg_on = 1'b0;
    m_vld = (lg_len >= SAMPLE_DLY + 1);
    m_pos = ph;
    push(m_dem && !force_ccm, m_dem && !force_ccm && m_vld && m_pos, tag);
    @(negedge clk);
    phase_pos = 1'b0;
  endtask

  task automatic set_force(input bit f, input string tag);
    @(negedge clk);
    force_ccm = f;
    if (f) begin m_dem = 0; m_cnt = 0; end
    push(m_dem && !f, m_dem && !f && m_vld && m_pos, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    push(1'b0, 1'b0, "R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(1'b0, 1'b0, "R1 after reset");

    // R4/R5: seven qualifying cycles then a miss, no entry
    for (int i = 0; i < 7; i++) pwm_cycle(1'b1, 8, "R5 run of seven");
    pwm_cycle(1'b0, 8, "R4 negative breaks run");
    pwm_cycle(1'b1, 8, "R4 run restart");
    // R3: short gate gives no sample, which is a miss
    for (int i = 0; i < 6; i++) pwm_cycle(1'b1, 8, "R3 run before short");
    pwm_cycle(1'b1, 2, "R3 short gate unsampled");
    pwm_cycle(1'b1, SAMPLE_DLY + 1, "R3 minimum sampled gate");

    // R5/R8: full run enters exactly at the eighth closing strobe
    for (int i = 0; i < 8; i++) pwm_cycle(1'b1, 8, "R5 R8 entry run");
    // R7: in DEM, reverse current requests turn-off
    pwm_cycle(1'b1, 8, "R7 request in DEM");
    // R9: unsampled cycle keeps DEM
    pwm_cycle(1'b1, 2, "R9 no sample in DEM");
    pwm_cycle(1'b1, 8, "R9 still DEM");
    // R6: forward current exits at next strobe
    pwm_cycle(1'b0, 8, "R6 forward current");
    pwm_cycle(1'b1, 8, "R6 exit on strobe");

    // R2: force during DEM, mid cycle
    for (int i = 0; i < 8; i++) pwm_cycle(1'b1, 8, "R2 re-entry");
    pwm_cycle(1'b1, 8, "R2 in DEM");
    @(negedge clk);
    pulse = 1'b1;
    m_vld = 0; m_pos = 0;
    push(1'b1, 1'b0, "R2 pulse before force");
    @(negedge clk);
    pulse = 1'b0; lg_on = 1'b1; phase_pos = 1'b1;
    repeat (6) @(negedge clk);
    m_vld = 1; m_pos = 1;
    push(1'b1, 1'b1, "R7 req before force");
    set_force(1'b1, "R2 force drops outputs");
    @(negedge clk);
    lg_on = 1'b0; phase_pos = 1'b0;
    pwm_cycle(1'b1, 8, "R2 forced cycle");
    pwm_cycle(1'b1, 8, "R2 forced cycle");
    set_force(1'b0, "R2 release");
    // partial run, force, then remainder must not enter
    for (int i = 0; i < 5; i++) pwm_cycle(1'b1, 8, "R2 partial run");
    set_force(1'b1, "R2 force clears count");
    set_force(1'b0, "R2 release again");
    for (int i = 0; i < 5; i++) pwm_cycle(1'b1, 8, "R2 remainder no entry");
    for (int i = 0; i < 5; i++) pwm_cycle(1'b1, 8, "R2 R5 fresh run enters");

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule